// File: doc/BRIEF.md
# Card Clock Divider with Bypass

This block derives the clock sent to a memory card from the master clock. A divider field D sets the card clock to the master frequency divided by 2·D, with a 50 % duty cycle. A D of zero passes the master clock straight through. In DDR mode that pass-through is not allowed, so a zero D is treated as 1. Requested values above the largest D the internal field can hold are clamped to that largest value.

Alongside the clock, the block gives the data path strobes that are one master cycle long. One marks each rising card-clock edge. A second marks each falling edge and is used only in DDR mode, where data is captured on both edges. The block also decodes the bus-width selection and the speed-mode bit into control outputs. A new divider value is taken up only when the card clock enters its low phase, so a change never cuts a high phase short. While the enable is low, the card clock stays low.

Top module: `card_clk_div`

## Requirements
- R1: For an effective divider D ≥ 1, the card clock period is 2·D master cycles, and card_clk is high for D of them.
- R2: With div_req = 0 and ddr_mode = 0, card_clk follows the master clock, and rise_stb is high in every master cycle.
- R3: With div_req = 0 and ddr_mode = 1, the block divides by 1, giving a period of 2 master cycles.
- R4: A div_req above 2^DIV_W − 1 is clamped to 2^DIV_W − 1 (63 with the defaults).
- R5: A divider change made during a high phase lets that high phase finish with the old D. The low phase that follows already uses the new D.
- R6: While clk_en is low, card_clk, rise_stb and fall_stb are all low.
- R7: When dividing, rise_stb is high for exactly the one master cycle that follows the rising edge of card_clk.
- R8: In DDR mode, fall_stb is high for the one master cycle that follows each falling edge of card_clk, D cycles after rise_stb. Outside DDR mode, fall_stb stays low.
- R9: The bus_w encoding is 0 = 1 bit, 1 = 4 bits, 2 = 8 bits, 3 = reserved. wide4 is high only for code 1 and wide8 only for code 2. speed_hi follows hs_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Card clock enable |
| ddr_mode | input | 1 | Selects capture on both edges; forbids bypass |
| div_req | input | REQ_W | Requested divider value D |
| bus_w | input | 2 | Bus width code |
| hs_mode | input | 1 | High-speed bus mode request |
| card_clk | output | 1 | Card clock |
| rise_stb | output | 1 | One-cycle pulse after each card clock rise |
| fall_stb | output | 1 | One-cycle pulse after each card clock fall (DDR only) |
| wide4 | output | 1 | 4-bit bus selected |
| wide8 | output | 1 | 8-bit bus selected |
| speed_hi | output | 1 | High-speed mode indication |

## Verification
The hardest case to reach is a divider change in the middle of a high phase. The stimulus waits for a rise_stb pulse, which marks the first cycle of a high phase, and writes the new value a few cycles later. It then counts the high and low samples of that same period separately. Bypass mode cannot be measured with negedge sampling alone, because card_clk equals the master clock there. The bench therefore samples it just after each rising edge as well.

// File: rtl/card_clk_div.sv
module card_clk_div #(
  parameter int REQ_W = 10,
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             ddr_mode,
  input  logic [REQ_W-1:0] div_req,
  input  logic [1:0]       bus_w,
  input  logic             hs_mode,
  output logic             card_clk,
  output logic             rise_stb,
  output logic             fall_stb,
  output logic             wide4,
  output logic             wide8,
  output logic             speed_hi
);
  localparam logic [DIV_W-1:0] DIV_MAX = '1;

  logic [DIV_W-1:0] div_sat, div_eff, d_act, cnt;
  logic             div_q, rise_q, fall_q;
  logic             bypass, last;

  assign div_sat = (div_req > REQ_W'(DIV_MAX)) ? DIV_MAX : div_req[DIV_W-1:0];
  assign div_eff = (div_sat == '0 && ddr_mode) ? DIV_W'(1) : div_sat;
  assign bypass  = (d_act == '0);
  assign last    = (cnt == d_act - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      d_act  <= DIV_MAX;
    end else if (!clk_en || bypass) begin
      cnt    <= '0;
      div_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
      d_act  <= div_eff;
    end else begin
      rise_q <= last && !div_q;
      fall_q <= last && div_q && ddr_mode;
      if (last) begin
        cnt   <= '0;
        div_q <= ~div_q;
        if (div_q) d_act <= div_eff;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign card_clk = (bypass && clk_en) ? clk : div_q;
  assign rise_stb = bypass ? clk_en : rise_q;
  assign fall_stb = fall_q;
  assign wide4    = (bus_w == 2'd1);
  assign wide8    = (bus_w == 2'd2);
  assign speed_hi = hs_mode;
endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk (
  input logic clk,
  input logic rst_n,
  input logic clk_en,
  input logic ddr_mode,
  input logic card_clk,
  input logic rise_stb,
  input logic fall_stb,
  input logic byp
);
  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !byp) |-> (card_clk && !$past(card_clk))); // R7

  AST_RISE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !byp) |=> (!rise_stb || byp)); // R7

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_stb && !byp) |-> (!card_clk && $past(card_clk) && $past(ddr_mode))); // R8

  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && $past(!clk_en)) |-> (!card_clk && !rise_stb && !fall_stb)); // R6
endmodule

bind card_clk_div card_clk_div_chk u_chk (
  .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ddr_mode(ddr_mode),
  .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb), .byp(bypass)
);

// File: tb/tb_card_clk_div.sv
module tb_card_clk_div;
  localparam int REQ_W = 10;
  localparam int DIV_W = 6;
  localparam int DMAX  = (1 << DIV_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0, clk_en = 1'b0, ddr_mode = 1'b0, hs_mode = 1'b0;
  logic [REQ_W-1:0] div_req = '0;
  logic [1:0] bus_w = '0;
  logic card_clk, rise_stb, fall_stb, wide4, wide8, speed_hi;

  int n_chk = 0, n_fail = 0;
  int q_per[$], q_hi[$];
  string q_tag[$];
  bit armed = 0;

  always #5 clk = ~clk;

  card_clk_div #(.REQ_W(REQ_W), .DIV_W(DIV_W)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ddr_mode(ddr_mode),
    .div_req(div_req), .bus_w(bus_w), .hs_mode(hs_mode),
    .card_clk(card_clk), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .wide4(wide4), .wide8(wide8), .speed_hi(speed_hi));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: measures period and high time, pops expectations
  initial begin
    int since = 0, hi_run = 0, last_hi = 0;
    bit have_last = 0, prev = 0;
    forever begin
      @(negedge clk);
      since++;
      if (card_clk && !prev) hi_run = 1;
      else if (card_clk) hi_run++;
      if (!card_clk && prev) last_hi = hi_run;
      if (rise_stb && card_clk && !prev) begin
        if (armed && have_last && q_per.size() > 0) begin
          int ep, eh;
          string t;
          ep = q_per.pop_front();
          eh = q_hi.pop_front();
          t = q_tag.pop_front();
          check(since == ep, t, since, ep);
          check(last_hi == eh, t, last_hi, eh);
        end
        since = 0;
        have_last = armed;
      end
      prev = card_clk;
    end
  end

  task automatic run_div(input int req, input bit ddr, input int d, input string tag);
    int guard;
    armed = 0;
    @(posedge clk); #2;
    div_req = REQ_W'(req);
    ddr_mode = ddr;
    repeat (300) @(posedge clk);
    armed = 1;
    for (int i = 0; i < 3; i++) begin
      q_per.push_back(2 * d);
      q_hi.push_back(d);
      q_tag.push_back(tag);
    end
    guard = 0;
    while (q_per.size() != 0 && guard < 2000) begin
      @(posedge clk);
      guard++;
    end
    check(q_per.size() == 0, {tag, " periods seen"}, q_per.size(), 0);
    q_per.delete(); q_hi.delete(); q_tag.delete();
    armed = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hi, lo, cyc;
    bit seen;
    repeat (3) @(negedge clk);
    check(card_clk == 0, "reset card_clk", card_clk, 0);
    check(rise_stb == 0 && fall_stb == 0, "reset strobes", rise_stb, 0);
    @(posedge clk); #2;
    rst_n = 1; clk_en = 1; div_req = 10'd2;

    run_div(1, 0, 1, "R1 D=1");
    run_div(2, 0, 2, "R1 D=2");
    run_div(5, 0, 5, "R1 D=5");
    run_div(0, 1, 1, "R3 ddr zero");
    run_div(700, 0, DMAX, "R4 saturate");
    run_div(DMAX, 0, DMAX, "R4 max exact");

    // R5: change during high phase
    run_div(4, 0, 4, "R5 setup");
    do @(negedge clk); while (!(rise_stb && card_clk));
    @(posedge clk); #2; div_req = 10'd6;
    hi = 1;
    @(negedge clk);
    while (card_clk) begin hi++; @(negedge clk); end
    lo = 0;
    while (!card_clk) begin lo++; @(negedge clk); end
    check(hi == 4, "R5 old high", hi, 4);
    check(lo == 6, "R5 new low", lo, 6);

    // R8: falling strobe in DDR
    run_div(3, 1, 3, "R8 ddr D=3");
    do @(negedge clk); while (!(rise_stb && card_clk));
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!fall_stb && cyc < 20);
    check(cyc == 3, "R8 fall delay", cyc, 3);
    check(card_clk == 0, "R8 fall level", card_clk, 0);
    @(posedge clk); #2; ddr_mode = 0;
    repeat (20) @(posedge clk);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (fall_stb) seen = 1;
    end
    check(!seen, "R8 no fall outside ddr", seen, 0);

    // R2: bypass
    @(posedge clk); #2; div_req = '0; ddr_mode = 0;
    repeat (20) @(posedge clk);
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      check(card_clk == 1, "R2 bypass high", card_clk, 1);
      @(negedge clk); #1;
      check(card_clk == 0, "R2 bypass low", card_clk, 0);
      check(rise_stb == 1, "R2 bypass strobe", rise_stb, 1);
    end

    // R6: enable low in bypass and divided
    @(posedge clk); #2; clk_en = 0;
    repeat (2) @(posedge clk);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      if (card_clk || rise_stb || fall_stb) seen = 1;
      @(negedge clk);
      if (card_clk || rise_stb || fall_stb) seen = 1;
    end
    check(!seen, "R6 off in bypass", seen, 0);
    @(posedge clk); #2; div_req = 10'd2; ddr_mode = 1;
    repeat (2) @(posedge clk);
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (card_clk || rise_stb || fall_stb) seen = 1;
    end
    check(!seen, "R6 off in divided", seen, 0);
    @(posedge clk); #2; clk_en = 1; ddr_mode = 0;
    run_div(2, 0, 2, "R6 resume");

    // R9: decode
    for (int b = 0; b < 4; b++) begin
      @(posedge clk); #2; bus_w = 2'(b); hs_mode = b[0];
      #1;
      check(wide4 == (b == 1), "R9 wide4", wide4, int'(b == 1));
      check(wide8 == (b == 2), "R9 wide8", wide8, int'(b == 2));
      check(speed_hi == b[0], "R9 speed_hi", speed_hi, b[0]);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule